// File: doc/BRIEF.md
# PLL Coefficient Reprogramming Sequencer

This block applies a new set of PLL coefficients (reference divider, feedback multiplier and post divider) without glitching the downstream clock. A single start pulse captures the requested coefficients. The sequencer then steps the PLL controls through a fixed order. It puts the output divider into 1:2 and lets it settle, then parks the clock output on the bypass source and disables the PLL. While the PLL is off it loads the coefficient register. It then re-enables the PLL, makes sure lock detection is active, and waits a bounded time for lock. Once the PLL is locked it returns the output to the VCO, lets it settle, and restores the divider to 1:1.

Each divider change is issued as two identical back-to-back write strobes. The 1:2 step splits the frequency jump across the bypass switch into two smaller steps. Settle and lock windows are given in microseconds and converted to clock cycles from the clock frequency parameter. The caller sees a busy flag, a one-cycle done pulse, and a sticky error flag when the lock wait expires.

Top module: `pll_reprog_seq`

## Requirements
- R1: After a start is accepted, `div_wr_o` is high for exactly two consecutive cycles with `div_sel_o`=1 (1 selects divide-by-2) before any other control changes.
- R2: `vco_sel_o` does not fall to bypass (0 = bypass, 1 = VCO) until at least SETTLE_CYC (CLK_MHZ*SETTLE_US) cycles after the second 1:2 write, and falls no more than 4 cycles later.
- R3: The output select is already at bypass in the cycle `pll_en_o` falls. `m_o`/`n_o`/`pl_o` change only while `pll_en_o`=0 and `vco_sel_o`=0. `pll_en_o` rises only after the coefficient update.
- R4: `lock_det_off_o` (reset value 1) is cleared after `pll_en_o` rises and before the lock wait begins, and then stays 0.
- R5: The lock wait lasts LOCK_CYC (CLK_MHZ*LOCK_US) cycles. If `lock_i` is not seen in that window, `err_o` rises between LOCK_CYC and LOCK_CYC+4 cycles after `pll_en_o` rises. At that point `busy_o` drops, `vco_sel_o` stays 0, no 1:1 writes are issued, and `pll_en_o` is left at 1.
- R6: `vco_sel_o` rises to VCO only after `lock_i` is seen high during the lock wait, and within 3 cycles of it.
- R7: Between SETTLE_CYC and SETTLE_CYC+3 cycles after `vco_sel_o` rises, `div_wr_o` is high for two consecutive cycles with `div_sel_o`=0 (1:1).
- R8: `busy_o` is high from the cycle after a start is accepted until the sequence ends. `done_o` is a one-cycle pulse in the first cycle with `busy_o` low.
- R9: `start_i` while `busy_o` is high is ignored. The coefficient inputs sampled at the accepted start are the ones applied, and no new sequence follows.
- R10: `err_o` stays high after a timeout until the next accepted start. It reads 0 in the cycle after that start.
- R11: After a successful run, `m_o`, `n_o` and `pl_o` equal the values on `m_i`, `n_i` and `pl_i` at the accepted start.
- R12: After reset, `div_sel_o`, `div_wr_o`, `vco_sel_o`, `pll_en_o`, `busy_o`, `done_o` and `err_o` are 0, and `lock_det_off_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to apply new coefficients |
| m_i | input | M_W | Requested reference divider |
| n_i | input | N_W | Requested feedback multiplier |
| pl_i | input | PL_W | Requested post divider code |
| lock_i | input | 1 | PLL lock indication |
| div_sel_o | output | 1 | Output divider value: 1 = 1:2, 0 = 1:1 |
| div_wr_o | output | 1 | Output divider write strobe |
| vco_sel_o | output | 1 | Output source: 1 = VCO, 0 = bypass |
| pll_en_o | output | 1 | PLL enable |
| lock_det_off_o | output | 1 | Lock detector disable |
| m_o | output | M_W | Applied reference divider |
| n_o | output | N_W | Applied feedback multiplier |
| pl_o | output | PL_W | Applied post divider code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky lock-timeout error |

## Verification
The assertions assume `lock_i` is synchronous to `clk_i`. They also assume it stays high for at least two cycles once it rises while the PLL is enabled, because the VCO-switch check looks two cycles back at the lock input. The bench's PLL model respects this. It raises lock a programmable number of cycles after it sees the PLL enabled with detection active, and holds lock until the enable falls. In the timeout case the model never raises lock. The bench drives `start_i` and the coefficient inputs only at falling edges. The only start pulse it issues during a run is the one meant to be ignored.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DIV2_A,
    S_DIV2_B,
    S_SET_W,
    S_BYP,
    S_DIS,
    S_WRC,
    S_EN,
    S_LDET,
    S_LWAIT,
    S_VCO,
    S_RST_W,
    S_DIV1_A,
    S_DIV1_B
  } seq_state_e;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W   = 14,
  parameter int MAX_LEN = 15000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             exp_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= len_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign exp_o = (cnt_q == '0);

  // R5
  tmr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < MAX_LEN);

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int M_W        = 8,
  parameter int N_W        = 8,
  parameter int PL_W       = 6,
  parameter int CNT_W      = 14,
  parameter int SETTLE_CYC = 100,
  parameter int LOCK_CYC   = 15000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [M_W-1:0]   m_i,
  input  logic [N_W-1:0]   n_i,
  input  logic [PL_W-1:0]  pl_i,
  input  logic             lock_i,
  input  logic             tmr_exp_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_len_o,
  output logic             div_sel_o,
  output logic             div_wr_o,
  output logic             vco_sel_o,
  output logic             pll_en_o,
  output logic             lock_det_off_o,
  output logic [M_W-1:0]   m_o,
  output logic [N_W-1:0]   n_o,
  output logic [PL_W-1:0]  pl_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  localparam logic [CNT_W-1:0] SET_LEN = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LCK_LEN = CNT_W'(LOCK_CYC - 1);

  seq_state_e state_q, state_d;
  logic [M_W-1:0]  m_req_q, m_q;
  logic [N_W-1:0]  n_req_q, n_q;
  logic [PL_W-1:0] pl_req_q, pl_q;
  logic div_sel_q, vco_sel_q, pll_en_q, ldo_q, done_q, err_q;
  logic lock_to;

  assign lock_to = (state_q == S_LWAIT) && !lock_i && tmr_exp_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = S_DIV2_A;
      S_DIV2_A: state_d = S_DIV2_B;
      S_DIV2_B: state_d = S_SET_W;
      S_SET_W:  if (tmr_exp_i) state_d = S_BYP;
      S_BYP:    state_d = S_DIS;
      S_DIS:    state_d = S_WRC;
      S_WRC:    state_d = S_EN;
      S_EN:     state_d = S_LDET;
      S_LDET:   state_d = S_LWAIT;
      S_LWAIT:  if (lock_i) state_d = S_VCO;
                else if (tmr_exp_i) state_d = S_IDLE;
      S_VCO:    state_d = S_RST_W;
      S_RST_W:  if (tmr_exp_i) state_d = S_DIV1_A;
      S_DIV1_A: state_d = S_DIV1_B;
      S_DIV1_B: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  // timer restarts on entry to any wait state
  assign tmr_load_o = (state_d != state_q) &&
                      (state_d == S_SET_W || state_d == S_RST_W || state_d == S_LWAIT);
  assign tmr_len_o  = (state_d == S_LWAIT) ? LCK_LEN : SET_LEN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      m_req_q   <= '0;
      n_req_q   <= '0;
      pl_req_q  <= '0;
      m_q       <= '0;
      n_q       <= '0;
      pl_q      <= '0;
      div_sel_q <= 1'b0;
      vco_sel_q <= 1'b0;
      pll_en_q  <= 1'b0;
      ldo_q     <= 1'b1;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_DIV1_B);
      unique case (state_q)
        S_IDLE: if (start_i) begin
          m_req_q   <= m_i;
          n_req_q   <= n_i;
          pl_req_q  <= pl_i;
          div_sel_q <= 1'b1;
          err_q     <= 1'b0;
        end
        S_BYP:   vco_sel_q <= 1'b0;
        S_DIS:   pll_en_q  <= 1'b0;
        S_WRC: begin
          m_q  <= m_req_q;
          n_q  <= n_req_q;
          pl_q <= pl_req_q;
        end
        S_EN:    pll_en_q  <= 1'b1;
        S_LDET:  ldo_q     <= 1'b0;
        S_LWAIT: if (lock_to) err_q <= 1'b1;
        S_VCO:   vco_sel_q <= 1'b1;
        S_RST_W: if (tmr_exp_i) div_sel_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign div_sel_o      = div_sel_q;
  assign div_wr_o       = (state_q == S_DIV2_A) || (state_q == S_DIV2_B) ||
                          (state_q == S_DIV1_A) || (state_q == S_DIV1_B);
  assign vco_sel_o      = vco_sel_q;
  assign pll_en_o       = pll_en_q;
  assign lock_det_off_o = ldo_q;
  assign m_o            = m_q;
  assign n_o            = n_q;
  assign pl_o           = pl_q;
  assign busy_o         = (state_q != S_IDLE);
  assign done_o         = done_q;
  assign err_o          = err_q;

  // R1 R7
  div_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_wr_o) |=> div_wr_o && $stable(div_sel_q));

  // R3
  byp_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_en_q) |-> !vco_sel_q && !$past(vco_sel_q));

  // R3
  coef_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({m_q, n_q, pl_q}) |-> !pll_en_q && !vco_sel_q);

  // R4
  ldet_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LWAIT) |-> !ldo_q && pll_en_q);

  // R5
  to_no_vco_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> !vco_sel_q && !busy_o);

  // R6
  vco_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vco_sel_q) |-> $past(lock_i, 2) && pll_en_q);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o && !err_q);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable({m_req_q, n_req_q, pl_req_q}));

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
  parameter int M_W       = 8,
  parameter int N_W       = 8,
  parameter int PL_W      = 6,
  parameter int CLK_MHZ   = 50,
  parameter int SETTLE_US = 2,
  parameter int LOCK_US   = 300
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [M_W-1:0]  m_i,
  input  logic [N_W-1:0]  n_i,
  input  logic [PL_W-1:0] pl_i,
  input  logic            lock_i,
  output logic            div_sel_o,
  output logic            div_wr_o,
  output logic            vco_sel_o,
  output logic            pll_en_o,
  output logic            lock_det_off_o,
  output logic [M_W-1:0]  m_o,
  output logic [N_W-1:0]  n_o,
  output logic [PL_W-1:0] pl_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int LOCK_CYC   = CLK_MHZ * LOCK_US;
  localparam int MAX_CYC    = (LOCK_CYC > SETTLE_CYC) ? LOCK_CYC : SETTLE_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_len;

  pll_seq_timer #(
    .CNT_W  (CNT_W),
    .MAX_LEN(MAX_CYC)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .len_i (tmr_len),
    .exp_o (tmr_exp)
  );

  pll_seq_fsm #(
    .M_W       (M_W),
    .N_W       (N_W),
    .PL_W      (PL_W),
    .CNT_W     (CNT_W),
    .SETTLE_CYC(SETTLE_CYC),
    .LOCK_CYC  (LOCK_CYC)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .m_i           (m_i),
    .n_i           (n_i),
    .pl_i          (pl_i),
    .lock_i        (lock_i),
    .tmr_exp_i     (tmr_exp),
    .tmr_load_o    (tmr_load),
    .tmr_len_o     (tmr_len),
    .div_sel_o     (div_sel_o),
    .div_wr_o      (div_wr_o),
    .vco_sel_o     (vco_sel_o),
    .pll_en_o      (pll_en_o),
    .lock_det_off_o(lock_det_off_o),
    .m_o           (m_o),
    .n_o           (n_o),
    .pl_o          (pl_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o)
  );

endmodule

// File: tb/sim_pll_reprog_seq.sv
`timescale 1ns/1ps
module sim_pll_reprog_seq;

  localparam int SETTLE = 100;
  localparam int LOCKW  = 15000;
  localparam int LIMIT  = 20000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] m_i = '0, n_i = '0;
  logic [5:0] pl_i = '0;
  logic       lock_i = 1'b0;
  logic       div_sel_o, div_wr_o, vco_sel_o, pll_en_o, lock_det_off_o;
  logic [7:0] m_o, n_o;
  logic [5:0] pl_o;
  logic       busy_o, done_o, err_o;

  int errs = 0, checks = 0;
  int lock_dly = 0;
  int lk_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pll_reprog_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .m_i(m_i), .n_i(n_i), .pl_i(pl_i),
    .lock_i(lock_i), .div_sel_o(div_sel_o), .div_wr_o(div_wr_o), .vco_sel_o(vco_sel_o),
    .pll_en_o(pll_en_o), .lock_det_off_o(lock_det_off_o), .m_o(m_o), .n_o(n_o), .pl_o(pl_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // PLL lock model
  always @(posedge clk) begin
    if (!pll_en_o || lock_det_off_o) begin
      lock_i <= 1'b0;
      lk_cnt  = 0;
    end else if (lk_cnt < lock_dly) lk_cnt = lk_cnt + 1;
    else lock_i <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reset_check();
    chk(!div_sel_o && !div_wr_o, "R12", "divider idle", {div_sel_o, div_wr_o}, 0);
    chk(!vco_sel_o && !pll_en_o, "R12", "vco/en low", {vco_sel_o, pll_en_o}, 0);
    chk(lock_det_off_o, "R12", "lock det off", lock_det_off_o, 1);
    chk(!busy_o && !done_o && !err_o, "R12", "flags low", {busy_o, done_o, err_o}, 0);
  endtask

  task automatic run_case(input string tag, input logic [7:0] m, input logic [7:0] n,
                          input logic [5:0] pl, input int ldly, input bit exp_to,
                          input bit poke);
    int  wr_n = 0;
    int  wr_cyc[4];
    bit  wr_sel[4];
    int  vco_fall = -1, vco_rise = -1, en_fall = -1, en_rise = -1;
    int  ldo_fall = -1, lock_rise = -1, coef_chg = -1, end_cyc = -1;
    bit  busy_ok = 1, coef_ok = 1, err_first = 0;
    bit  pv_vco, pv_en, pv_ldo, pv_lock;
    logic [21:0] pv_coef;
    lock_dly = ldly;
    @(negedge clk);
    start_i = 1'b1; m_i = m; n_i = n; pl_i = pl;
    pv_vco = vco_sel_o; pv_en = pll_en_o; pv_ldo = lock_det_off_o; pv_lock = lock_i;
    pv_coef = {pl_o, n_o, m_o};
    for (int c = 1; c <= LIMIT; c++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (c == 1) err_first = err_o;
      if (poke && c == 50) begin
        start_i = 1'b1; m_i = ~m; n_i = ~n; pl_i = ~pl;
      end
      if (div_wr_o) begin
        if (wr_n < 4) begin wr_cyc[wr_n] = c; wr_sel[wr_n] = div_sel_o; end
        wr_n++;
      end
      if (pv_vco && !vco_sel_o) vco_fall = c;
      if (!pv_vco && vco_sel_o) vco_rise = c;
      if (pv_en && !pll_en_o) en_fall = c;
      if (!pv_en && pll_en_o) en_rise = c;
      if (pv_ldo && !lock_det_off_o) ldo_fall = c;
      if (!pv_lock && lock_i) lock_rise = c;
      if ({pl_o, n_o, m_o} != pv_coef) begin
        coef_chg = c;
        if (pll_en_o || vco_sel_o) coef_ok = 0;
      end
      if (done_o || err_o) begin end_cyc = c; break; end
      if (!busy_o) busy_ok = 0;
      pv_vco = vco_sel_o; pv_en = pll_en_o; pv_ldo = lock_det_off_o; pv_lock = lock_i;
      pv_coef = {pl_o, n_o, m_o};
    end
    $display("case %s ends at cycle %0d", tag, end_cyc);
    chk(!err_first, "R10", "err cleared after start", err_first, 0);
    chk(end_cyc > 0, "R8", "sequence ends", end_cyc, 1);
    chk(busy_ok, "R8", "busy held during run", busy_ok, 1);
    chk(!busy_o, "R8", "busy low at end", busy_o, 0);
    chk(wr_n >= 2 && wr_sel[0] && wr_sel[1] && wr_cyc[1] == wr_cyc[0] + 1, "R1",
        "two 1:2 writes", wr_n, 2);
    if (vco_fall > 0) begin
      chk(vco_fall - wr_cyc[1] >= SETTLE && vco_fall - wr_cyc[1] <= SETTLE + 4, "R2",
          "settle before bypass", vco_fall - wr_cyc[1], SETTLE + 2);
      chk(en_fall > vco_fall, "R3", "bypass before disable", en_fall, vco_fall + 1);
    end
    chk(coef_ok, "R3", "coef changed while disabled", coef_ok, 1);
    if (coef_chg > 0)
      chk(en_rise > coef_chg, "R3", "enable after coef write", en_rise, coef_chg + 1);
    if (ldo_fall > 0)
      chk(ldo_fall > en_rise, "R4", "lock det on after enable", ldo_fall, en_rise + 1);
    chk(!lock_det_off_o, "R4", "lock det stays on", lock_det_off_o, 0);
    if (exp_to) begin
      chk(err_o && !done_o, "R5", "timeout flagged", {err_o, done_o}, 2);
      chk(!vco_sel_o && pll_en_o, "R5", "no vco switch, enable kept",
          {vco_sel_o, pll_en_o}, 1);
      chk(end_cyc - en_rise >= LOCKW && end_cyc - en_rise <= LOCKW + 4, "R5",
          "lock window", end_cyc - en_rise, LOCKW + 1);
      chk(wr_n == 2, "R5", "no 1:1 writes", wr_n, 2);
    end else begin
      chk(done_o && !err_o, "R8", "done pulse", {done_o, err_o}, 2);
      chk(vco_rise > lock_rise && vco_rise - lock_rise <= 3, "R6", "vco after lock",
          vco_rise - lock_rise, 2);
      chk(vco_sel_o && pll_en_o, "R6", "on vco at end", {vco_sel_o, pll_en_o}, 3);
      chk(wr_n == 4 && !wr_sel[2] && !wr_sel[3] && wr_cyc[3] == wr_cyc[2] + 1, "R7",
          "two 1:1 writes", wr_n, 4);
      chk(wr_cyc[2] - vco_rise >= SETTLE && wr_cyc[2] - vco_rise <= SETTLE + 3, "R7",
          "settle before 1:1", wr_cyc[2] - vco_rise, SETTLE);
      chk(m_o == m && n_o == n && pl_o == pl, "R11", "applied coefficients",
          {pl_o, n_o, m_o}, {pl, n, m});
      @(negedge clk);
      chk(!done_o, "R8", "done one cycle", done_o, 0);
    end
  endtask

  task automatic idle_check(input string req, input int cycles);
    bit quiet = 1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (busy_o || div_wr_o) quiet = 0;
    end
    chk(quiet, req, "no further sequence", quiet, 1);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_check();
    rst_ni = 1'b1;
    @(negedge clk);
    reset_check();
    run_case("from_reset", 8'd1, 8'd40, 6'd2, 20, 1'b0, 1'b0);
    // R9: start pulse and new inputs mid-run are ignored
    run_case("reprog_poke", 8'd2, 8'd99, 6'd5, 5, 1'b0, 1'b1);
    idle_check("R9", 30);
    run_case("timeout", 8'd3, 8'd77, 6'd1, 1000000, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    chk(err_o, "R10", "error sticky", err_o, 1);
    run_case("late_lock", 8'd4, 8'd200, 6'd9, 14000, 1'b0, 1'b0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule